// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block merges three reset causes into a single active-low system reset output: a synchronised low-supply flag, a programmable watchdog that software must restart periodically, and a manual reset pin. The manual pin is synchronised and then debounced. Each cause produces a reset that lasts a fixed minimum time, and a status flag records whether the most recent reset came from the watchdog. All timing runs from a one-cycle clock enable, `tick_ms`, that pulses once per millisecond.

Software uses a small register port. It sets the watchdog timeout, restarts the watchdog, and reads or clears the cause flag. The timeout is a 5-bit code counted in steps of `STEP_TICKS` ticks. Code 0 turns the watchdog off, and the watchdog is off after reset. The defaults are a 100-tick stretch, a 10-tick debounce and 100-tick timeout steps. With a 1 ms tick this gives a 100 ms stretch, a 10 ms debounce and timeouts from 100 ms to 3 s.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_low` is 1, `sys_rst_n` is 0 from the clock edge after the flag is first sampled high.
- R2: After every reset cause ends, `sys_rst_n` returns to 1 on exactly the `STRETCH_TICKS`-th tick edge that follows. A supply reset ends when the flag is cleared. A watchdog or manual reset ends at the edge that triggers it.
- R3: With a nonzero code C, the watchdog expires on the (C*`STEP_TICKS`)-th tick after a restart and then asserts reset. With code 0 it never expires.
- R4: The register at address 0 holds the timeout code in bits [4:0], and its reset value is 0. A written value above `MAX_CODE` (30) is stored as 30. Every other read bit is 0.
- R5: Any write to address 1 restarts the watchdog and clears its partial count. A restart that arrives on the same edge as the final tick prevents that expiry.
- R6: The watchdog count stays at zero while reset is asserted. After release, it counts a full timeout from zero.
- R7: Bit 0 at address 2 is the watchdog-cause flag, and its reset value is 0. A watchdog expiry sets it. Writing 1 to that bit clears it, and so does a supply-low condition or an accepted manual press.
- R8: The manual pin `man_rst_n` passes through two flip-flops. It is accepted as pressed only after it has been low on `DEBOUNCE_TICKS` consecutive ticks, so shorter low pulses have no effect on the output.
- R9: An accepted press produces one reset of `STRETCH_TICKS` ticks. Keeping the pin held low does not extend or repeat that reset.
- R10: While `rst_n` is 0, `sys_rst_n` is 0. After `rst_n` is released, `sys_rst_n` stays low for `STRETCH_TICKS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms | input | 1 | One-cycle timebase enable |
| supply_low | input | 1 | Synchronised low-supply indication |
| man_rst_n | input | 1 | Raw manual reset pin, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sys_rst_n | output | 1 | Stretched active-low system reset |

## Verification
The critical collision is a watchdog restart write that lands on the same clock edge as the final timeout tick. The bench restarts the watchdog and waits exactly one tick less than the timeout. It then issues the restart so that the write strobe is sampled on the expiry edge. The result passes only if `sys_rst_n` stays high through that edge, and only if the next expiry then comes one full timeout after the late restart.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_KICK = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam int unsigned REG_W    = 8;
endpackage

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
  parameter int unsigned DEB_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  output logic press
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);

  logic          sync1_q, sync2_q, acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    press = 1'b0;
    if (sync2_q != acc_q) begin
      if (tick) begin
        if (cnt_q == CW'(DEB_TICKS - 1)) begin
          acc_d = sync2_q;
          cnt_d = '0;
          press = !sync2_q;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      acc_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= pin_n;
      sync2_q <= sync1_q;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8: a press is accepted only after the synchronised pin was already low
  p_press_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    press |-> !$past(sync2_q));
  // R9: one acceptance per press
  p_press_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog #(
  parameter int unsigned STEP_TICKS = 100,
  parameter int unsigned MAX_CODE   = 30,
  parameter int unsigned CODE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  logic              kick,
  input  logic              hold,
  output logic              expire
);
  localparam int unsigned CW = $clog2(MAX_CODE * STEP_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          enabled;

  always_comb begin
    enabled = (code != '0);
    limit   = CW'(code) * CW'(STEP_TICKS);
    expire  = tick && enabled && !hold && !kick && (cnt_q >= limit - CW'(1));
    cnt_d   = cnt_q;
    if (hold || kick || !enabled) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = expire ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: no expiry while disabled
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int unsigned LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  input  logic level,
  output logic busy,
  output logic rst_out_n
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q;

  always_comb begin
    cnt_d = cnt_q;
    if (trig || level)                 cnt_d = CW'(LEN);
    else if (tick && (cnt_q != '0))    cnt_d = cnt_q - CW'(1);
    busy = level || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(LEN);
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= (cnt_d == '0);
    end
  end

  assign rst_out_n = out_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int unsigned STRETCH_TICKS  = 100,
  parameter int unsigned DEBOUNCE_TICKS = 10,
  parameter int unsigned STEP_TICKS     = 100,
  parameter int unsigned MAX_CODE       = 30,
  parameter int unsigned CODE_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             supply_low,
  input  logic             man_rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sys_rst_n
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              flag_q, flag_d;
  logic              kick, clr_flag, man_press, wd_exp, rst_busy;

  assign kick     = reg_we && (reg_addr == ADDR_KICK);
  assign clr_flag = reg_we && (reg_addr == ADDR_STAT) && reg_wdata[0];

  rsup_debounce #(.DEB_TICKS(DEBOUNCE_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .pin_n(man_rst_n), .press(man_press)
  );

  rsup_watchdog #(.STEP_TICKS(STEP_TICKS), .MAX_CODE(MAX_CODE), .CODE_W(CODE_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .code(code_q), .kick(kick),
    .hold(rst_busy), .expire(wd_exp)
  );

  rsup_stretch #(.LEN(STRETCH_TICKS)) u_str (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .trig(wd_exp || man_press),
    .level(supply_low), .busy(rst_busy), .rst_out_n(sys_rst_n)
  );

  always_comb begin
    code_d = code_q;
    if (reg_we && (reg_addr == ADDR_CTRL)) begin
      if (reg_wdata > REG_W'(MAX_CODE)) code_d = CODE_W'(MAX_CODE);
      else                              code_d = reg_wdata[CODE_W-1:0];
    end
    flag_d = flag_q;
    if (wd_exp)                        flag_d = 1'b1;
    else if (supply_low || man_press)  flag_d = 1'b0;
    else if (clr_flag)                 flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = {{(REG_W - CODE_W){1'b0}}, code_q};
      ADDR_STAT: reg_rdata = {{(REG_W - 1){1'b0}}, flag_q};
      default:   reg_rdata = '0;
    endcase
  end

  // R1: supply-low drives the output low on the following edge
  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !sys_rst_n);
  // R2: release never happens while supply-low was present
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> !$past(supply_low));
  // R3: an expiry asserts the reset output
  p_expire_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_exp |=> !sys_rst_n);
  // R6: the watchdog cannot expire while reset is asserted
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> !wd_exp);
  // R7: expiry records the watchdog as cause
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_exp |=> flag_q);
  // R4: stored code stays inside the legal range
  p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CODE_W'(MAX_CODE));
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  logic       clk = 1'b0;
  logic       rst_n, tick_ms, supply_low, man_rst_n, reg_we, sys_rst_n;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam int unsigned NV = 6;
  localparam int unsigned VEC [NV][2] = '{'{0, 0}, '{1, 1}, '{15, 15},
                                          '{30, 30}, '{31, 30}, '{255, 30}};

  always #10 clk = ~clk;

  rst_supervisor i_rst_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_low(supply_low),
    .man_rst_n(man_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #2;
    v = int'(reg_rdata);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    rst_n = 1'b0; tick_ms = 1'b1; supply_low = 1'b0; man_rst_n = 1'b1;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
    edges(3);
    chk("R10 output low in reset", int'(sys_rst_n), 0);
    rd(2'd0, v); chk("R4 code reset value", v, 0);
    rd(2'd2, v); chk("R7 flag reset value", v, 0);
    rst_n = 1'b1;
    edges(99); chk("R10 still stretched", int'(sys_rst_n), 0);
    edges(1);  chk("R10 released after stretch", int'(sys_rst_n), 1);

    // R4 code field write/readback with clamping
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 8'(VEC[i][0]));
      rd(2'd0, v);
      chk("R4 code readback", v, int'(VEC[i][1]));
    end
    wr(2'd0, 8'd0);

    // R3 watchdog expiry, code 1 -> 100 ticks
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd0);
    edges(99); chk("R3 no expiry before timeout", int'(sys_rst_n), 1);
    edges(1);  chk("R3 expiry asserts reset", int'(sys_rst_n), 0);
    rd(2'd2, v); chk("R7 flag set by expiry", v, 1);
    edges(99); chk("R2 watchdog reset still low", int'(sys_rst_n), 0);
    edges(1);  chk("R2 watchdog reset length", int'(sys_rst_n), 1);
    edges(99); chk("R6 full timeout after release", int'(sys_rst_n), 1);
    edges(1);  chk("R6 expiry timed from release", int'(sys_rst_n), 0);
    wr(2'd2, 8'd1);
    rd(2'd2, v); chk("R7 write-one clears flag", v, 0);
    edges(98); chk("R2 second reset low", int'(sys_rst_n), 0);
    edges(1);  chk("R2 second reset released", int'(sys_rst_n), 1);

    // R5 restart on the final tick edge
    wr(2'd1, 8'd0);
    edges(99); chk("R5 before late restart", int'(sys_rst_n), 1);
    wr(2'd1, 8'd0);
    chk("R5 late restart blocks expiry", int'(sys_rst_n), 1);
    edges(99); chk("R5 count restarted", int'(sys_rst_n), 1);
    edges(1);  chk("R5 expiry after late restart", int'(sys_rst_n), 0);
    edges(100); chk("R2 reset after late restart", int'(sys_rst_n), 1);
    wr(2'd0, 8'd0);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      edges(1);
      if (!sys_rst_n) n++;
    end
    chk("R3 code 0 disables watchdog", n, 0);

    // R8 glitch shorter than debounce is ignored
    man_rst_n = 1'b0; edges(5); man_rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      edges(1);
      if (!sys_rst_n) n++;
    end
    chk("R8 short pulse ignored", n, 0);
    rd(2'd2, v); chk("R8 short pulse leaves flag", v, 1);

    // R8/R9 accepted press
    man_rst_n = 1'b0;
    edges(11); chk("R8 not yet accepted", int'(sys_rst_n), 1);
    edges(1);  chk("R8 press accepted", int'(sys_rst_n), 0);
    rd(2'd2, v); chk("R7 manual press clears flag", v, 0);
    edges(99); chk("R9 manual reset low", int'(sys_rst_n), 0);
    edges(1);  chk("R9 manual reset length", int'(sys_rst_n), 1);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      edges(1);
      if (!sys_rst_n) n++;
    end
    chk("R9 holding does not repeat", n, 0);
    man_rst_n = 1'b1;
    edges(20);

    // R1/R2 supply-low
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd0);
    edges(10);
    supply_low = 1'b1;
    edges(1);  chk("R1 supply low asserts", int'(sys_rst_n), 0);
    rd(2'd2, v); chk("R7 supply keeps flag clear", v, 0);
    edges(150); chk("R1 held while low", int'(sys_rst_n), 0);
    rd(2'd2, v); chk("R6 no expiry during supply reset", v, 0);
    supply_low = 1'b0;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      edges(1);
      n++;
      if (sys_rst_n) break;
    end
    chk("R2 supply release delay", n, 100);
    edges(99); chk("R6 timeout counted from release", int'(sys_rst_n), 1);
    wr(2'd0, 8'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule